// File: doc/BRIEF.md
# Dual Byte-Addressed Countdown Timers

This block holds two 16-bit down-counters behind a byte-wide register window of sixteen slots. Both counters advance only on a one-cycle `tick` enable, so the count rate is set by whatever prescaler drives `tick` and not by the system clock. The first timer owns a full 16-bit reload value. In periodic mode it runs forever: it counts down past zero to all-ones and then reloads. The second timer is one-shot. A two-byte write sequence arms it, and it reports a single expiry.

Neither timer holds an interrupt flag of its own. Each timer drives a one-cycle "set" pulse and a one-cycle "clear" pulse toward a separate interrupt-flag block. Certain register reads and writes have side effects: some load a counter, some request a flag clear. The periodic-mode select comes in as two bits taken from the auxiliary control register, which lives outside this block.

Top module: `dtmr_top`

## Requirements
- R1: After reset the slots read as follows: timer A counter bytes (slots 4 and 5) read 0xFF, timer A reload bytes (slots 6 and 7) read 0xFF, and timer B counter bytes (slots 8 and 9) read 0xFF. The stored low byte of timer B is 0x00, so a first write of value V to slot 9 loads 16'h{V,00}.
- R2: On each tick, timer A moves to counter-1. When the counter is 0xFFFF it instead takes the reload value. One full cycle therefore lasts reload+2 ticks.
- R3: When a tick brings timer A's counter to zero and `t1_mode` is 2'b01, `t1_flag_set` pulses for one cycle. The pulse comes in the cycle after that tick edge, while the counter reads zero.
- R4: With any `t1_mode` other than 2'b01, `t1_flag_set` never pulses. Counting and reload go on unchanged.
- R5: Reading slot 4 returns counter bits 7..0 and pulses `t1_flag_clr` in the next cycle. Reading slot 5 returns counter bits 15..8 and has no side effect.
- R6: Writing slot 4 or slot 6 sets reload bits 7..0. Writing slot 5 sets reload bits 15..8, loads the counter with the full new reload value, and pulses `t1_flag_clr`. Writing slot 7 sets reload bits 15..8 and pulses `t1_flag_clr`, but leaves the counter alone.
- R7: Writing slot 8 stores a low byte for timer B. Writing slot 9 with V loads timer B's counter with {V, stored low byte}. Reading slot 8 returns counter bits 7..0 and pulses `t2_flag_clr` in the next cycle. Slot 9 reads counter bits 15..8.
- R8: Timer B decrements on every tick and wraps from 0 to 0xFFFF. `t2_flag_set` pulses only on the first such wrap after a load from slot 9, and not on later wraps.
- R9: The slot number is `addr[12:9]`; the other address bits have no effect. Slots other than 4 to 9 read 0x00 and ignore writes. `rdata` is 0x00 when `rd_en` is low.
- R10: Without a tick and without a counter-loading write, neither counter changes.
- R11: A counter load from slot 5 or slot 9 takes priority over a tick in the same cycle. A set pulse that would coincide with a clear pulse of the same timer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| addr | input | 13 | Byte address; bits 12..9 pick the slot |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from current state |
| t1_mode | input | 2 | Timer A mode bits; 2'b01 selects periodic flags |
| t1_flag_set | output | 1 | Pulse: set timer A flag |
| t1_flag_clr | output | 1 | Pulse: clear timer A flag |
| t2_flag_set | output | 1 | Pulse: set timer B flag |
| t2_flag_clr | output | 1 | Pulse: clear timer B flag |

## Verification
Read data depends only on the current state and the current slot number, so it is valid in the same cycle as `rd_en`. The bench drives each access just after a rising edge and compares `rdata` at the falling edge of that cycle. Counter and reload updates appear after the edge that samples the write or tick, so the next read shows them. All four flag pulses are registered. They appear in the cycle after the edge that caused them, and the monitor counts them at falling edges. Pulse counts are compared only after one further falling edge, so every pulse caused by a step has been counted before the comparison.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] SLOT_A_CLO = 4'd4;
  localparam logic [IDX_W-1:0] SLOT_A_CHI = 4'd5;
  localparam logic [IDX_W-1:0] SLOT_A_RLO = 4'd6;
  localparam logic [IDX_W-1:0] SLOT_A_RHI = 4'd7;
  localparam logic [IDX_W-1:0] SLOT_B_CLO = 4'd8;
  localparam logic [IDX_W-1:0] SLOT_B_CHI = 4'd9;

  localparam logic [1:0] MODE_PERIODIC = 2'b01;

  typedef struct packed {
    logic a_lo_wr;    // reload low byte write (slot 4 or 6)
    logic a_hi_load;  // reload high byte write plus counter load
    logic a_hi_hold;  // reload high byte write, counter untouched
    logic a_lo_rd;    // counter low byte read (flag clear)
    logic b_lo_wr;    // stored low byte write
    logic b_hi_wr;    // counter load
    logic b_lo_rd;    // counter low byte read (flag clear)
  } strobes_t;
endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [IDX_W-1:0]  idx,
  output strobes_t          stb
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[IDX_LSB-1:0];
  assign idx = addr[IDX_LSB +: IDX_W];

  always_comb begin
    stb           = '0;
    stb.a_lo_wr   = wr_en && (idx == SLOT_A_CLO || idx == SLOT_A_RLO);
    stb.a_hi_load = wr_en && (idx == SLOT_A_CHI);
    stb.a_hi_hold = wr_en && (idx == SLOT_A_RHI);
    stb.a_lo_rd   = rd_en && (idx == SLOT_A_CLO);
    stb.b_lo_wr   = wr_en && (idx == SLOT_B_CLO);
    stb.b_hi_wr   = wr_en && (idx == SLOT_B_CHI);
    stb.b_lo_rd   = rd_en && (idx == SLOT_B_CLO);
  end
endmodule

// File: rtl/dtmr_periodic.sv
module dtmr_periodic
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lo_wr,
  input  logic              hi_load,
  input  logic              hi_hold,
  input  logic              lo_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  reload,
  output logic              flag_set,
  output logic              flag_clr
);
  logic [CNT_W-1:0] cnt_d, reload_d;
  logic             set_d, clr_d, hit;

  always_comb begin
    reload_d = reload;
    if (lo_wr) reload_d[BYTE_W-1:0] = wdata;
    if (hi_load || hi_hold) reload_d[CNT_W-1:BYTE_W] = wdata;

    cnt_d = cnt;
    hit   = 1'b0;
    if (hi_load) begin
      cnt_d = {wdata, reload[BYTE_W-1:0]};
    end else if (tick) begin
      if (cnt == '1) cnt_d = reload;
      else           cnt_d = cnt - 1'b1;
      hit = (cnt_d == '0);
    end

    clr_d = lo_rd || hi_load || hi_hold;
    set_d = hit && (mode == MODE_PERIODIC) && !clr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '1;
      reload   <= '1;
      flag_set <= 1'b0;
      flag_clr <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      reload   <= reload_d;
      flag_set <= set_d;
      flag_clr <= clr_d;
    end
  end
endmodule

// File: rtl/dtmr_oneshot.sv
module dtmr_oneshot
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              lo_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag_set,
  output logic              flag_clr
);
  logic [BYTE_W-1:0] low_q, low_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              armed_q, armed_d;
  logic              fire, set_d, clr_d;

  always_comb begin
    low_d   = lo_wr ? wdata : low_q;
    cnt_d   = cnt;
    armed_d = armed_q;
    fire    = 1'b0;
    if (hi_wr) begin
      cnt_d   = {wdata, low_q};
      armed_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt - 1'b1;
      if (cnt == '0 && armed_q) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end
    end
    clr_d = lo_rd;
    set_d = fire && !clr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= '0;
      cnt      <= '1;
      armed_q  <= 1'b0;
      flag_set <= 1'b0;
      flag_clr <= 1'b0;
    end else begin
      low_q    <= low_d;
      cnt      <= cnt_d;
      armed_q  <= armed_d;
      flag_set <= set_d;
      flag_clr <= clr_d;
    end
  end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [1:0]        t1_mode,
  output logic              t1_flag_set,
  output logic              t1_flag_clr,
  output logic              t2_flag_set,
  output logic              t2_flag_clr
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [IDX_W-1:0] idx;
  strobes_t         stb;
  logic [CNT_W-1:0] a_cnt, a_reload, b_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dtmr_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_decode (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .idx(idx), .stb(stb)
  );

  dtmr_periodic u_tmr_a (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .mode(t1_mode), .wdata(wdata),
    .lo_wr(stb.a_lo_wr), .hi_load(stb.a_hi_load), .hi_hold(stb.a_hi_hold),
    .lo_rd(stb.a_lo_rd), .cnt(a_cnt), .reload(a_reload),
    .flag_set(t1_flag_set), .flag_clr(t1_flag_clr)
  );

  dtmr_oneshot u_tmr_b (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .wdata(wdata),
    .lo_wr(stb.b_lo_wr), .hi_wr(stb.b_hi_wr), .lo_rd(stb.b_lo_rd),
    .cnt(b_cnt), .flag_set(t2_flag_set), .flag_clr(t2_flag_clr)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (idx)
        SLOT_A_CLO: rdata = a_cnt[BYTE_W-1:0];
        SLOT_A_CHI: rdata = a_cnt[CNT_W-1:BYTE_W];
        SLOT_A_RLO: rdata = a_reload[BYTE_W-1:0];
        SLOT_A_RHI: rdata = a_reload[CNT_W-1:BYTE_W];
        SLOT_B_CLO: rdata = b_cnt[BYTE_W-1:0];
        SLOT_B_CHI: rdata = b_cnt[CNT_W-1:BYTE_W];
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       t1_mode,
  input logic [CNT_W-1:0] a_cnt,
  input logic [CNT_W-1:0] a_reload,
  input logic [CNT_W-1:0] b_cnt,
  input logic             t1_flag_set,
  input logic             t1_flag_clr,
  input logic             t2_flag_set,
  input logic             t2_flag_clr
);
  // R2
  reload_after_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && a_cnt == '1) |=> (a_cnt == $past(a_reload)));
  // R3
  set_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_flag_set |-> (a_cnt == '0));
  // R4
  no_set_other_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_mode != MODE_PERIODIC) |=> !t1_flag_set);
  // R6
  load_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == SLOT_A_CHI) |=> t1_flag_clr);
  // R8
  oneshot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2_flag_set |-> (b_cnt == '1));
  // R10
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(a_cnt) && $stable(b_cnt)));
  // R11
  a_set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(t1_flag_set && t1_flag_clr));
  // R11
  b_set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(t2_flag_set && t2_flag_clr));
endmodule

bind dtmr_top dtmr_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .tick(tick), .wr_en(wr_en), .idx(idx),
  .t1_mode(t1_mode), .a_cnt(a_cnt), .a_reload(a_reload), .b_cnt(b_cnt),
  .t1_flag_set(t1_flag_set), .t1_flag_clr(t1_flag_clr),
  .t2_flag_set(t2_flag_set), .t2_flag_clr(t2_flag_clr)
);

// File: tb/dtmr_top_bench.sv
module dtmr_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick, wr_en, rd_en;
  logic [12:0] addr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  t1_mode;
  logic        t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr;

  int total = 0, bad = 0;
  int n_aset = 0, n_aclr = 0, n_bset = 0, n_bclr = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmr_top u_dtmr_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .t1_mode(t1_mode),
    .t1_flag_set(t1_flag_set), .t1_flag_clr(t1_flag_clr),
    .t2_flag_set(t2_flag_set), .t2_flag_clr(t2_flag_clr)
  );

  // monitor: pulse counting and read scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      n_aset += int'(t1_flag_set);
      n_aclr += int'(t1_flag_clr);
      n_bset += int'(t2_flag_set);
      n_bclr += int'(t2_flag_clr);
    end
    if (rd_en) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: read with no expected item, actual=%02h expected=none", rdata);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (rdata !== e.val) begin
          bad++;
          $display("FAIL %s: rdata actual=%02h expected=%02h", e.tag, rdata, e.val);
        end
      end
    end
  end

  function automatic logic [12:0] sa(input int slot);
    return 13'(slot << 9);
  endfunction

  task automatic step(input logic tk, input logic rd, input logic wr,
                      input logic [12:0] a, input logic [7:0] d,
                      input logic [7:0] ev, input string tag);
    tick = tk; rd_en = rd; wr_en = wr; addr = a; wdata = d;
    if (rd) begin
      exp_t e;
      e.tag = tag; e.val = ev;
      expq.push_back(e);
    end
    @(posedge clk); #1;
    tick = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input int slot, input logic [7:0] ev, input string tag);
    step(1'b0, 1'b1, 1'b0, sa(slot), 8'h00, ev, tag);
  endtask

  task automatic wr(input int slot, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, sa(slot), d, 8'h00, "");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, '0, 8'h00, 8'h00, "");
  endtask

  task automatic chk_cnt(input int act, input int expv, input string tag);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: count actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic settle;
    @(negedge clk); #1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, c;
    rst_n = 0; tick = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; t1_mode = 2'b01;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) begin @(posedge clk); #1; end

    // R1 reset values
    rd(4, 8'hFF, "R1 A cnt lo"); rd(5, 8'hFF, "R1 A cnt hi");
    rd(6, 8'hFF, "R1 A reload lo"); rd(7, 8'hFF, "R1 A reload hi");
    rd(8, 8'hFF, "R1 B cnt lo"); rd(9, 8'hFF, "R1 B cnt hi");
    // R9 unused slot
    rd(0, 8'h00, "R9 slot0");
    // R1/R7 stored low byte is zero after reset
    wr(9, 8'h01);
    rd(8, 8'h00, "R1 B low latch"); rd(9, 8'h01, "R7 B hi load");

    // R6 reload writes, slot 7 does not load
    settle; c = n_aclr;
    wr(6, 8'h03); wr(7, 8'h00);
    settle; chk_cnt(n_aclr, c + 1, "R6 slot7 clear pulse");
    rd(4, 8'hFF, "R6 slot7 no load");
    rd(6, 8'h03, "R6 reload lo"); rd(7, 8'h00, "R6 reload hi");
    settle; c = n_aclr;
    wr(5, 8'h00);
    settle; chk_cnt(n_aclr, c + 1, "R6 slot5 clear pulse");
    rd(4, 8'h03, "R6 slot5 load");
    // R5 slot 5 read: no clear pulse
    settle; c = n_aclr;
    rd(5, 8'h00, "R5 hi read");
    settle; chk_cnt(n_aclr, c, "R5 hi read no side effect");

    // R3 / R2 periodic operation, reload 3 -> period 5
    s = n_aset;
    ticks(3);
    settle; chk_cnt(n_aset, s + 1, "R3 set at zero");
    c = n_aclr;
    rd(4, 8'h00, "R3 cnt zero");
    settle; chk_cnt(n_aclr, c + 1, "R5 lo read clears");
    ticks(1); rd(5, 8'hFF, "R2 passes all-ones");
    ticks(1); rd(4, 8'h03, "R2 reload");
    ticks(3);
    settle; chk_cnt(n_aset, s + 2, "R2 period reload+2");

    // R11 tick + clear read in the same cycle
    ticks(4);  // 0 -> FFFF -> 3 -> 2 -> 1
    s = n_aset; c = n_aclr;
    step(1'b1, 1'b1, 1'b0, sa(4), 8'h00, 8'h01, "R11 read before tick");
    settle;
    chk_cnt(n_aset, s, "R11 set dropped on clear");
    chk_cnt(n_aclr, c + 1, "R11 clear kept");
    rd(4, 8'h00, "R11 counted to zero");

    // R10 hold without tick
    repeat (5) step(1'b0, 1'b0, 1'b0, '0, 8'h00, 8'h00, "");
    rd(4, 8'h00, "R10 hold lo"); rd(5, 8'h00, "R10 hold hi");

    // R4 non-periodic mode
    t1_mode = 2'b00;
    wr(5, 8'h00);
    s = n_aset;
    ticks(5);
    settle; chk_cnt(n_aset, s, "R4 no set mode00");
    rd(4, 8'h03, "R4 still reloads");
    t1_mode = 2'b11;
    ticks(3);
    settle; chk_cnt(n_aset, s, "R4 no set mode11");
    t1_mode = 2'b01;

    // R9 address decoding
    step(1'b0, 1'b0, 1'b1, sa(6) | 13'h1FF, 8'h05, 8'h00, "");
    step(1'b0, 1'b1, 1'b0, sa(6) | 13'h0AA, 8'h00, 8'h05, "R9 low bits ignored");
    wr(3, 8'h55); rd(3, 8'h00, "R9 unused write"); rd(12, 8'h00, "R9 unused read");

    // R11 load beats tick; R7 timer B
    wr(8, 8'h02);
    step(1'b1, 1'b0, 1'b1, sa(9), 8'h00, 8'h00, "");
    c = n_bclr;
    rd(8, 8'h02, "R11 load over tick");
    rd(9, 8'h00, "R7 B hi");
    settle; chk_cnt(n_bclr, c + 1, "R7 read clears");

    // R8 one-shot
    s = n_bset;
    ticks(2);
    settle; chk_cnt(n_bset, s, "R8 no set at zero");
    ticks(1);
    settle; chk_cnt(n_bset, s + 1, "R8 set on wrap");
    rd(9, 8'hFF, "R8 wrapped");
    ticks(65536);
    settle; chk_cnt(n_bset, s + 1, "R8 no second set");
    rd(8, 8'hFF, "R8 wraps freely");
    wr(9, 8'h00);
    ticks(3);
    settle; chk_cnt(n_bset, s + 2, "R8 rearm by load");

    settle;
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: leftover actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule